// File: doc/BRIEF.md
# Reader Preamble Detector and Classifier

This block listens to a digitised receive line coming from an RF front end and picks a valid packet preamble out of noise. It samples the line once per sample tick. The tick period is a fixed fraction of the basic pulse period. For each high and low phase the block counts how many samples it lasts. A valid preamble is a train of regular pulses followed by one longer sync pulse. The high time of that sync pulse shows whether the sender was an interrogator (reader) or another tag.

Only a reader preamble leads to a one-cycle `reader_found` strobe, which starts the downstream data decoder. A tag preamble raises a one-cycle `tag_seen` strobe that can be used for statistics. Any phase that breaks the timing windows makes the block drop the train and go back to listening. A synchronous enable holds the block idle, for example while the tag is transmitting.

Top module: `preamble_classifier`

## Requirements
- R1: During reset and right after it, `reader_found`, `tag_seen` and `busy` are all 0.
- R2: A train of 20 regular pulses, each 4 samples high and 4 samples low, followed by a sync pulse of 7 samples high and 7 samples low and then a rising edge, produces exactly one `reader_found` pulse one clock wide and no `tag_seen`.
- R3: The same train with a sync high phase of 5 samples produces exactly one `tag_seen` pulse and no `reader_found`.
- R4: A regular high or low phase is accepted only if it lasts 3 to 5 samples. A phase of 2 or 6 samples causes the train to be rejected.
- R5: The sync pulse is recognised only after exactly 20 regular pulses. Trains of 17 to 19 or of 21 to 23 regular pulses give no strobe.
- R6: A sync high phase is accepted only at exactly 5 samples (tag) or exactly 7 samples (reader). Any other length gives no strobe.
- R7: The sync low phase must last 6 to 8 samples and end with a rising edge. Lows of 4, 5, 9 or 10 samples give no strobe.
- R8: A rising edge that ends a regular low phase shorter than the minimum starts a new train, with the pulse count at zero and that edge as the first pulse. A falling edge that ends a too-short high phase returns the block to listening, and a later rising edge starts a new train. In both cases a full valid preamble that follows is still found.
- R9: While `en` is 0 the block stays idle: `busy`, `reader_found` and `tag_seen` remain 0 even when a full reader preamble arrives.
- R10: `busy` is 1 while a train is being tracked and 0 while the block is listening.
- R11: The line is sampled once every `TICK_CYCLES` clock cycles after a `SYNC_STAGES`-flop synchroniser. A level held for N·`TICK_CYCLES` cycles counts as N samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Synchronous enable; 0 holds the block idle |
| rx_line | input | 1 | Digitised receive line from the RF front end (asynchronous) |
| reader_found | output | 1 | One-cycle strobe: valid reader preamble detected |
| tag_seen | output | 1 | One-cycle strobe: valid tag preamble detected |
| busy | output | 1 | A preamble train is being tracked |

## Verification
The bench sweeps every pair of regular high and low lengths from 2 to 6 samples. This separates the accepted 3-to-5 window from the lengths just outside it on both sides. Separate sweeps vary the number of regular pulses around 20, the sync high length from 3 to 9 and the sync low length from 4 to 10, so that reader, tag and reject are each told apart at their exact boundaries. Further cases cover trains broken by a short low or a short high and then followed by a clean preamble, a preamble sent while the block is disabled, and the `busy` level partway through a train. The expected strobe counts are computed from the window rules in the bench.

// File: rtl/pd_pkg.sv
package pd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_REG_HI  = 3'd1,
    ST_REG_LO  = 3'd2,
    ST_SYNC_HI = 3'd3,
    ST_SYNC_LO = 3'd4
  } pd_state_t;

  // true when v lies inside the closed window [lo, hi]
  function automatic logic in_window(input int v, input int lo, input int hi);
    return (v >= lo) && (v <= hi);
  endfunction

  // a phase that has already lasted 'run' samples and sees one more
  // identical sample is too long when it passes 'limit'
  function automatic logic overruns(input int run, input int limit);
    return (run + 1) > limit;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pd_sync.sv
module pd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '0;
        else        sr <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '0;
        else        sr <= {sr[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sr[STAGES-1];
endmodule

// File: rtl/pd_tick_gen.sv
module pd_tick_gen #(
  parameter int PERIOD = 248
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = $clog2(PERIOD + 1);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!en)        cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  assign tick = en && (cnt == LAST);

  generate
    if (PERIOD > 1) begin : g_gap
      // R11: two ticks are never adjacent
      p_tick_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/pd_fsm.sv
module pd_fsm
  import pd_pkg::*;
#(
  parameter int REG_PULSES     = 20,
  parameter int REG_MIN        = 3,
  parameter int REG_MAX        = 5,
  parameter int SYNC_HI_TAG    = 5,
  parameter int SYNC_HI_READER = 7,
  parameter int SYNC_LO_MIN    = 6,
  parameter int SYNC_LO_MAX    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic s,
  output logic reader_found,
  output logic tag_seen,
  output logic busy
);
  localparam int SYNC_HI_MAX = max_of(SYNC_HI_READER, SYNC_HI_TAG);
  localparam int RUN_MAX     = max_of(max_of(REG_MAX, SYNC_HI_MAX), SYNC_LO_MAX);
  localparam int RUN_W       = $clog2(RUN_MAX + 2);
  localparam int CNT_W       = $clog2(REG_PULSES + 1);

  pd_state_t        state, st_n;
  logic [RUN_W-1:0] run, run_n;
  logic [CNT_W-1:0] pulses, pul_n;
  logic             prev_s;
  logic             reader_sync, rdr_n;
  logic             found_q, tag_q;

  // named internal events
  logic reject, hit_reader, hit_tag;

  always_comb begin
    st_n       = state;
    run_n      = run;
    pul_n      = pulses;
    rdr_n      = reader_sync;
    reject     = 1'b0;
    hit_reader = 1'b0;
    hit_tag    = 1'b0;
    if (tick) begin
      unique case (state)
        ST_IDLE: begin
          if (s && !prev_s) begin
            st_n  = ST_REG_HI;
            run_n = RUN_W'(1);
            pul_n = '0;
          end
        end
        ST_REG_HI: begin
          if (s) begin
            if (overruns(int'(run), REG_MAX)) reject = 1'b1;
            else run_n = run + 1'b1;
          end else if (in_window(int'(run), REG_MIN, REG_MAX)) begin
            st_n  = ST_REG_LO;
            run_n = RUN_W'(1);
          end else begin
            reject = 1'b1;
          end
        end
        ST_REG_LO: begin
          if (!s) begin
            if (overruns(int'(run), REG_MAX)) reject = 1'b1;
            else run_n = run + 1'b1;
          end else if (in_window(int'(run), REG_MIN, REG_MAX)) begin
            pul_n = pulses + 1'b1;
            run_n = RUN_W'(1);
            st_n  = (int'(pulses) + 1 == REG_PULSES) ? ST_SYNC_HI : ST_REG_HI;
          end else begin
            // early rising edge: this edge opens a fresh train
            st_n  = ST_REG_HI;
            run_n = RUN_W'(1);
            pul_n = '0;
          end
        end
        ST_SYNC_HI: begin
          if (s) begin
            if (overruns(int'(run), SYNC_HI_MAX)) reject = 1'b1;
            else run_n = run + 1'b1;
          end else if (int'(run) == SYNC_HI_READER) begin
            rdr_n = 1'b1;
            st_n  = ST_SYNC_LO;
            run_n = RUN_W'(1);
          end else if (int'(run) == SYNC_HI_TAG) begin
            rdr_n = 1'b0;
            st_n  = ST_SYNC_LO;
            run_n = RUN_W'(1);
          end else begin
            reject = 1'b1;
          end
        end
        ST_SYNC_LO: begin
          if (!s) begin
            if (overruns(int'(run), SYNC_LO_MAX)) reject = 1'b1;
            else run_n = run + 1'b1;
          end else if (in_window(int'(run), SYNC_LO_MIN, SYNC_LO_MAX)) begin
            hit_reader = reader_sync;
            hit_tag    = !reader_sync;
            st_n       = ST_IDLE;
            run_n      = '0;
            pul_n      = '0;
          end else begin
            reject = 1'b1;
          end
        end
        default: reject = 1'b1;
      endcase
      if (reject) begin
        st_n  = ST_IDLE;
        run_n = '0;
        pul_n = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      run         <= '0;
      pulses      <= '0;
      prev_s      <= 1'b1;
      reader_sync <= 1'b0;
      found_q     <= 1'b0;
      tag_q       <= 1'b0;
    end else if (!en) begin
      state       <= ST_IDLE;
      run         <= '0;
      pulses      <= '0;
      prev_s      <= 1'b1;
      reader_sync <= 1'b0;
      found_q     <= 1'b0;
      tag_q       <= 1'b0;
    end else begin
      state       <= st_n;
      run         <= run_n;
      pulses      <= pul_n;
      reader_sync <= rdr_n;
      found_q     <= hit_reader;
      tag_q       <= hit_tag;
      if (tick) prev_s <= s;
    end
  end

  assign reader_found = found_q;
  assign tag_seen     = tag_q;
  assign busy         = (state != ST_IDLE);

  // R2/R3: never both verdicts at once
  p_one_verdict_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(reader_found && tag_seen));
  // R2: reader strobe is one cycle wide
  p_found_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reader_found |=> !reader_found);
  // R2: a reader strobe only follows a tick taken in the sync low phase
  p_found_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reader_found |-> ($past(state) == ST_SYNC_LO && $past(tick) && $past(reader_sync)));
  // R3: a tag strobe only follows a tag-length sync
  p_tag_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tag_seen |-> ($past(state) == ST_SYNC_LO && $past(tick) && !$past(reader_sync)));
  // R4: a regular phase never holds more samples than the window allows
  p_reg_run_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_REG_HI || state == ST_REG_LO) |-> int'(run) <= REG_MAX);
  // R5: the sync phase is entered only with the full pulse count
  p_sync_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SYNC_HI && $past(state) != ST_SYNC_HI) |-> int'(pulses) == REG_PULSES);
  // R7: the sync low run stays within its limit
  p_sync_lo_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SYNC_LO) |-> int'(run) <= SYNC_LO_MAX);
  // R9: disabling forces idle and silence on the next cycle
  p_disabled_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!busy && !reader_found && !tag_seen));
endmodule

// File: rtl/preamble_classifier.sv
module preamble_classifier #(
  parameter int TICK_CYCLES    = 248,
  parameter int SYNC_STAGES    = 2,
  parameter int REG_PULSES     = 20,
  parameter int REG_MIN        = 3,
  parameter int REG_MAX        = 5,
  parameter int SYNC_HI_TAG    = 5,
  parameter int SYNC_HI_READER = 7,
  parameter int SYNC_LO_MIN    = 6,
  parameter int SYNC_LO_MAX    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic rx_line,
  output logic reader_found,
  output logic tag_seen,
  output logic busy
);
  logic rx_s;
  logic tick;

  pd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (rx_line),
    .q     (rx_s)
  );

  pd_tick_gen #(.PERIOD(TICK_CYCLES)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .tick  (tick)
  );

  pd_fsm #(
    .REG_PULSES     (REG_PULSES),
    .REG_MIN        (REG_MIN),
    .REG_MAX        (REG_MAX),
    .SYNC_HI_TAG    (SYNC_HI_TAG),
    .SYNC_HI_READER (SYNC_HI_READER),
    .SYNC_LO_MIN    (SYNC_LO_MIN),
    .SYNC_LO_MAX    (SYNC_LO_MAX)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (en),
    .tick         (tick),
    .s            (rx_s),
    .reader_found (reader_found),
    .tag_seen     (tag_seen),
    .busy         (busy)
  );
endmodule

// File: tb/tb_preamble_classifier.sv
module tb_preamble_classifier;
  localparam int TICK = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1;
  logic rx = 1'b0;
  logic reader_found, tag_seen, busy;

  int checks = 0;
  int errors = 0;
  int nf = 0, nt = 0, nb = 0;
  bit done = 0;

  always #10 clk = ~clk;

  preamble_classifier #(.TICK_CYCLES(TICK)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (en),
    .rx_line      (rx),
    .reader_found (reader_found),
    .tag_seen     (tag_seen),
    .busy         (busy)
  );

  always @(negedge clk) begin
    if (reader_found) nf++;
    if (tag_seen)     nt++;
    if (busy)         nb++;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic level(input logic v, input int n);
    rx = v;
    repeat (n * TICK) @(negedge clk);
  endtask

  task automatic train(input int n, input int hi, input int lo, input int sh, input int sl);
    for (int i = 0; i < n; i++) begin
      level(1'b1, hi);
      level(1'b0, lo);
    end
    level(1'b1, sh);
    level(1'b0, sl);
    level(1'b1, 3);
  endtask

  function automatic bit win(input int v, input int lo, input int hi);
    return v >= lo && v <= hi;
  endfunction

  function automatic bit body_ok(input int n, input int hi, input int lo, input int sl);
    return n == 20 && win(hi, 3, 5) && win(lo, 3, 5) && win(sl, 6, 8);
  endfunction

  task automatic run_case(input string req, input int n, input int hi, input int lo,
                          input int sh, input int sl);
    int f0, t0, ef, et;
    level(1'b0, 12);
    f0 = nf; t0 = nt;
    train(n, hi, lo, sh, sl);
    level(1'b0, 12);
    ef = (en && body_ok(n, hi, lo, sl) && sh == 7) ? 1 : 0;
    et = (en && body_ok(n, hi, lo, sl) && sh == 5) ? 1 : 0;
    check(req, $sformatf("reader strobes n=%0d hi=%0d lo=%0d sh=%0d sl=%0d", n, hi, lo, sh, sl),
          nf - f0, ef);
    check(req, $sformatf("tag strobes n=%0d hi=%0d lo=%0d sh=%0d sl=%0d", n, hi, lo, sh, sl),
          nt - t0, et);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int f0, b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "found in reset", int'(reader_found), 0);
    check("R1", "tag in reset", int'(tag_seen), 0);
    check("R1", "busy in reset", int'(busy), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "busy after reset", int'(busy), 0);

    // R2 R11: nominal reader and tag preambles
    run_case("R2 R11", 20, 4, 4, 7, 7);
    run_case("R3", 20, 4, 4, 5, 7);

    // R4: regular window sweep
    for (int hi = 2; hi <= 6; hi++)
      for (int lo = 2; lo <= 6; lo++)
        run_case("R4", 20, hi, lo, 7, 7);

    // R5: pulse count sweep
    for (int n = 17; n <= 23; n++) run_case("R5", n, 4, 4, 7, 7);

    // R6: sync high sweep
    for (int sh = 3; sh <= 9; sh++) run_case("R6", 20, 4, 4, sh, 7);

    // R7: sync low sweep, for reader and tag
    for (int sl = 4; sl <= 10; sl++) begin
      run_case("R7", 20, 4, 4, 7, sl);
      run_case("R7", 20, 4, 4, 5, sl);
    end

    // R8: short low restarts; the edge begins a clean train
    level(1'b0, 12);
    f0 = nf;
    for (int i = 0; i < 5; i++) begin level(1'b1, 4); level(1'b0, 4); end
    level(1'b1, 4);
    level(1'b0, 2);
    train(20, 4, 4, 7, 7);
    level(1'b0, 12);
    check("R8", "found after short-low restart", nf - f0, 1);

    // R8: short high drops to listening; next rising edge restarts
    f0 = nf;
    for (int i = 0; i < 5; i++) begin level(1'b1, 4); level(1'b0, 4); end
    level(1'b1, 2);
    level(1'b0, 4);
    train(20, 4, 4, 7, 7);
    level(1'b0, 12);
    check("R8", "found after short-high drop", nf - f0, 1);

    // R10: busy during a train, idle after
    level(1'b0, 12);
    check("R10", "busy while listening", int'(busy), 0);
    for (int i = 0; i < 10; i++) begin level(1'b1, 4); level(1'b0, 4); end
    check("R10", "busy mid-train", int'(busy), 1);
    for (int i = 0; i < 10; i++) begin level(1'b1, 4); level(1'b0, 4); end
    level(1'b1, 7); level(1'b0, 7); level(1'b1, 3);
    level(1'b0, 12);
    check("R10", "busy after preamble", int'(busy), 0);

    // R9: disabled block ignores a full reader preamble
    en = 1'b0;
    b0 = nb;
    run_case("R9", 20, 4, 4, 7, 7);
    check("R9", "busy cycles while disabled", nb - b0, 0);
    en = 1'b1;
    run_case("R9", 20, 4, 4, 7, 7);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule